// File: doc/BRIEF.md
# Restoring Binary Divider (Integer and Fraction Modes)

This block divides an unsigned W-bit dividend by an unsigned W-bit divisor over several clock cycles. Each cycle it makes one quotient bit: it shifts a 2W-bit working register one place left and tries to subtract the divisor from the upper half. A successful trial keeps the difference and produces a 1. A failed trial leaves the upper half unchanged and produces a 0. After W steps the quotient is in a separate shift register and the remainder is in the upper half of the working register.

One datapath serves two modes. In integer mode the dividend goes into the low half of the working register. The quotient is then the integer quotient, and the remainder is the integer remainder. In fraction mode both operands are read as fractions with the binary point at their left edge, so the dividend goes into the high half. Before any shift, the block checks whether the dividend is at least the divisor. If so, the quotient would not be a fraction, and the block reports divide overflow at once. A zero divisor is reported as overflow in either mode.

A caller pulses `start` while `busy` is low. It then waits for the one-cycle `done` pulse and reads `quotient`, `remainder` and `ovf`. These outputs hold their values until the next accepted start.

Top module: `restoring_divider`

## Requirements
- R1: While reset is asserted, and after it is released, the block is idle: `busy`, `done`, `ovf`, `quotient` and `remainder` are all 0.
- R2: With `frac_mode`=0 and a non-zero divisor d, the outputs are `quotient` = floor(D/d) and `remainder` = D mod d, where D is the dividend. For example, with W=6, 45/6 gives 7 remainder 3.
- R3: With `frac_mode`=1 and D < d, the outputs are `quotient` = floor(D·2^W/d) and `remainder` = (D·2^W) mod d. The quotient is a fraction whose binary point is at its left.
- R4: With `frac_mode`=1 and D >= d (d non-zero), the block sets `ovf`=1 and `quotient`=`remainder`=0, and pulses `done` in the cycle right after the start is accepted. No iteration takes place.
- R5: A zero divisor gives `ovf`=1, `quotient`=`remainder`=0 and `done` one cycle after the accepted start, in both modes.
- R6: A division without overflow keeps `busy` high for exactly W cycles after the start edge. `done` rises W+1 clock edges after the start edge, and `busy` and `done` are never high together.
- R7: `done` is high for a single cycle. `quotient`, `remainder` and `ovf` keep their values until the next accepted start.
- R8: A `start` pulse while `busy` is high is ignored. The running division finishes with the operands it was started with.
- R9: A division that completes without overflow clears `ovf`, even if the previous division overflowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request a division; accepted only while `busy` is low |
| frac_mode | input | 1 | 0 = integer division, 1 = fraction division |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient bits |
| remainder | output | W | Remainder (upper half of the working register) |
| ovf | output | 1 | Divide overflow or zero divisor |

## Verification
A wrong internal state most often shows up as a wrong quotient bit or remainder when `done` fires, which is at most W+1 cycles after the start. A divisor register that is corrupted while busy breaks the invariant that the partial remainder stays below the divisor. The checks therefore compare every result against arithmetic over all operand pairs of a 4-bit build in both modes. A control fault shows up as `done` arriving at the wrong edge, so latency is measured at the ports for overflow and non-overflow cases. A faulty overflow pre-check shows up as a fraction result with `ovf` clear, or as a result that arrives after W+1 cycles instead of after one.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_RUN  = 1'b1
  } rd_state_e;
endpackage

// File: rtl/rdiv_trial_sub.sv
module rdiv_trial_sub #(
  parameter int W = 8
) (
  input  logic [W:0]   part,
  input  logic [W-1:0] dvsr,
  output logic [W:0]   diff,
  output logic         fits
);
  logic [W+1:0] wide;

  always_comb begin
    wide = {1'b0, part} - {2'b00, dvsr};
    fits = ~wide[W+1];
    diff = wide[W:0];
  end
endmodule

// File: rtl/rdiv_precheck.sv
module rdiv_precheck #(
  parameter int W = 8
) (
  input  logic         frac,
  input  logic [W-1:0] dvnd,
  input  logic [W-1:0] dvsr,
  output logic         bad
);
  logic zero_dvsr;
  logic too_big;

  always_comb begin
    zero_dvsr = (dvsr == '0);
    too_big   = frac && (dvnd >= dvsr);
    bad       = zero_dvsr || too_big;
  end
endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pre_bad,
  output logic accept,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  rd_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    done_d = 1'b0;
    accept = start && (st_q == RD_IDLE);
    load   = accept && !pre_bad;
    step   = (st_q == RD_RUN);
    if (accept && pre_bad) begin
      done_d = 1'b1;
    end
    if (load) begin
      st_d   = RD_RUN;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end
    if (step) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        st_d   = RD_IDLE;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy = (st_q == RD_RUN);
  assign done = done_q;

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= LAST));

  // R6
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == LAST) |=> (!busy && done));
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         frac_mode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         ovf
);
  localparam int AW = 2 * W;

  logic [1:0]    rsync_q;
  logic          rst_i_n;
  logic [AW-1:0] acc_q, acc_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  dsr_q;
  logic          ovf_q, ovf_d;
  logic          acc_en, quo_en, ovf_en;
  logic          accept, load, step, pre_bad;
  logic [AW:0]   shifted;
  logic [W:0]    trial_diff;
  logic          trial_fits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rsync_q[1];

  rdiv_precheck #(.W(W)) precheck_i (
    .frac (frac_mode),
    .dvnd (dividend),
    .dvsr (divisor),
    .bad  (pre_bad)
  );

  rdiv_ctrl #(.W(W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (start),
    .pre_bad (pre_bad),
    .accept  (accept),
    .load    (load),
    .step    (step),
    .busy    (busy),
    .done    (done)
  );

  assign shifted = {acc_q, 1'b0};

  rdiv_trial_sub #(.W(W)) trial_i (
    .part (shifted[AW:W]),
    .dvsr (dsr_q),
    .diff (trial_diff),
    .fits (trial_fits)
  );

  always_comb begin
    acc_d  = acc_q;
    quo_d  = quo_q;
    ovf_d  = ovf_q;
    acc_en = 1'b0;
    quo_en = 1'b0;
    ovf_en = 1'b0;
    if (accept) begin
      acc_en = 1'b1;
      quo_en = 1'b1;
      ovf_en = 1'b1;
      quo_d  = '0;
      ovf_d  = pre_bad;
      if (pre_bad) begin
        acc_d = '0;
      end else if (frac_mode) begin
        acc_d = {dividend, {W{1'b0}}};
      end else begin
        acc_d = {{W{1'b0}}, dividend};
      end
    end else if (step) begin
      acc_en = 1'b1;
      quo_en = 1'b1;
      quo_d  = {quo_q[W-2:0], trial_fits};
      if (trial_fits) begin
        acc_d = {trial_diff[W-1:0], shifted[W-1:0]};
      end else begin
        acc_d = shifted[AW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      acc_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (quo_en) quo_q <= quo_d;
      if (ovf_en) ovf_q <= ovf_d;
      if (accept) dsr_q <= divisor;
    end
  end

  assign quotient  = quo_q;
  assign remainder = acc_q[AW-1:W];
  assign ovf       = ovf_q;

  // R2
  rem_below_dsr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |-> (remainder < dsr_q));

  // R3
  diff_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && trial_fits) |-> (trial_diff[W] == 1'b0));

  // R4
  frac_ovf_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (start && !busy && frac_mode && divisor != '0 && dividend >= divisor)
      |=> (done && ovf && quotient == '0 && remainder == '0));

  // R5
  zero_dsr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (start && !busy && divisor == '0) |=> (done && ovf));

  // R6
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |-> !done);

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(ovf)));

  // R8
  dsr_keep_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && start) |=> $stable(dsr_q));

  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |-> !ovf);
endmodule

// File: tb/restoring_divider_tb.sv
module restoring_divider_tb_top;
  logic clk;
  logic rst_n;

  logic       start, frac_mode;
  logic [3:0] dividend, divisor;
  logic       busy, done, ovf;
  logic [3:0] quotient, remainder;

  logic       b_start, b_frac;
  logic [5:0] b_dvnd, b_dvsr;
  logic       b_busy, b_done, b_ovf;
  logic [5:0] b_quo, b_rem;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  restoring_divider #(.W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frac_mode(frac_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .ovf(ovf)
  );

  restoring_divider #(.W(6)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .start(b_start), .frac_mode(b_frac),
    .dividend(b_dvnd), .divisor(b_dvsr), .busy(b_busy), .done(b_done),
    .quotient(b_quo), .remainder(b_rem), .ovf(b_ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run4(input bit fr, input int dd, input int dv, input bit post);
    int lat;
    int n;
    int eq;
    int er;
    bit eo;
    @(negedge clk);
    start = 1'b1; frac_mode = fr; dividend = 4'(dd); divisor = 4'(dv);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    eo = (dv == 0) || (fr && dd >= dv);
    n = fr ? (dd << 4) : dd;
    eq = eo ? 0 : n / dv;
    er = eo ? 0 : n % dv;
    if (eo) begin
      chk(ovf == 1'b1, fr ? "R4 ovf" : "R5 ovf", int'(ovf), 1);
      chk(lat == 1, "R5 ovf latency", lat, 1);
    end else begin
      // R9 ovf cleared on clean result
      chk(ovf == 1'b0, "R9 ovf", int'(ovf), 0);
      chk(lat == 5, "R6 latency", lat, 5);
    end
    chk(int'(quotient) == eq, fr ? "R3 quotient" : "R2 quotient", int'(quotient), eq);
    chk(int'(remainder) == er, fr ? "R3 remainder" : "R2 remainder", int'(remainder), er);
    chk(busy == 1'b0, "R6 busy at done", int'(busy), 0);
    if (post) begin
      @(negedge clk);
      chk(done == 1'b0, "R7 done pulse", int'(done), 0);
      chk(int'(quotient) == eq, "R7 hold quotient", int'(quotient), eq);
      chk(int'(remainder) == er, "R7 hold remainder", int'(remainder), er);
    end
  endtask

  task automatic run6(input bit fr, input int dd, input int dv, input int eq, input int er);
    int lat;
    @(negedge clk);
    b_start = 1'b1; b_frac = fr; b_dvnd = 6'(dd); b_dvsr = 6'(dv);
    @(negedge clk);
    b_start = 1'b0;
    lat = 1;
    while (!b_done && lat < 30) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 7, "R6 latency W6", lat, 7);
    chk(int'(b_quo) == eq, fr ? "R3 quotient W6" : "R2 quotient W6", int'(b_quo), eq);
    chk(int'(b_rem) == er, fr ? "R3 remainder W6" : "R2 remainder W6", int'(b_rem), er);
    chk(b_ovf == 1'b0, "R9 ovf W6", int'(b_ovf), 0);
  endtask

  initial begin
    int lat;
    rst_n = 1'b0;
    start = 1'b0; frac_mode = 1'b0; dividend = '0; divisor = '0;
    b_start = 1'b0; b_frac = 1'b0; b_dvnd = '0; b_dvsr = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(busy == 0 && done == 0 && ovf == 0, "R1 flags in reset", int'({busy, done, ovf}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && ovf == 0, "R1 flags after reset", int'({busy, done, ovf}), 0);
    chk(quotient == 0 && remainder == 0, "R1 data after reset", int'({quotient, remainder}), 0);

    run6(1'b0, 45, 6, 7, 3);
    run6(1'b1, 5, 9, 35, 5);
    run6(1'b0, 63, 1, 63, 0);

    for (int m = 0; m < 2; m++) begin
      for (int dd = 0; dd < 16; dd++) begin
        for (int dv = 0; dv < 16; dv++) begin
          run4(m[0], dd, dv, (dd == dv) || (dv == 0) || (dd == 15));
        end
      end
    end

    // R9: overflow followed by clean divide
    run4(1'b1, 9, 3, 1'b0);
    run4(1'b1, 2, 3, 1'b1);

    // R8: start pulses while busy are ignored
    @(negedge clk);
    start = 1'b1; frac_mode = 1'b0; dividend = 4'd13; divisor = 4'd3;
    @(negedge clk);
    frac_mode = 1'b1; dividend = 4'd2; divisor = 4'd0;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 5, "R8 latency unchanged", lat, 5);
    chk(int'(quotient) == 4, "R8 quotient", int'(quotient), 4);
    chk(int'(remainder) == 1, "R8 remainder", int'(remainder), 1);
    chk(ovf == 1'b0, "R8 ovf", int'(ovf), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule